// File: doc/BRIEF.md
# Stream engine run-control and end-of-frame tracker

This block governs one direction of a streaming bit-rearrangement engine. A small control word held inside the block carries enable, pause and halt levels together with mode bits. From these and from datapath events (input beat read, output beat written, end-of-frame, write-back complete) a four-state machine decides when the datapath may run. The current state is exposed as a one-hot status vector.

When an end-of-frame (EOF) arrives, the block loads a programmable count of trailing bits. It then counts that down on the input side or on the output side, as selected, and raises a one-cycle done pulse when the count reaches zero. With the dummy-read mode selected, the engine can finish the tail on synthesized input. The block also records the number of input bytes seen in the frame at each EOF. A loss flag is set when a later EOF arrives while a recorded count is still held. Two trigger bits in the control word are self-clearing: one clears the EOF record, the other emits a one-cycle FIFO reset pulse.

Top module: `stream_runctl`

## Requirements
- R1: After reset, ctl_rdata reads 0x04 (halt set, all else clear), st_onehot shows idle, run_en is 0, and eof_valid, eof_lost and eof_bytes are 0.
- R2: st_onehot always has exactly one bit set: bit 0 idle, bit 1 run, bit 2 wait, bit 3 pause.
- R3: Control word layout: bit 0 enable, bit 1 pause, bit 2 halt, bit 3 halt_drop, bit 4 tail_on_out, bit 5 dummy_rd, bit 6 fifo reset trigger, bit 7 trace-clear trigger. When run or pause is left because halt is 1 or enable is 0, halt_drop=0 enters wait. Wait stays until ev_wb_done and then goes to idle. With halt_drop=1 the state goes straight to idle and wb_discard pulses for one cycle.
- R4: Halt (or enable low) takes priority over pause, and pause takes priority over run. Run or pause is entered from idle only with enable=1 and halt=0. The state follows a control write one clock after ctl_rdata shows it.
- R5: With tail_on_out=0 the trailing count drops by BEAT_BITS on each ev_in_rd, and ev_out_wr is ignored. With tail_on_out=1 only ev_out_wr counts. Counting happens only in run.
- R6: tail_done is high for one cycle on the edge where the remaining trailing count reaches zero. When trail_bits is 0 at EOF, it is high on the EOF edge itself.
- R7: With dummy_rd=1 and the tail counted on the input side, dummy_in is high while in run with a tail pending. Each such cycle consumes one beat without ev_in_rd. With dummy_rd=0, dummy_in stays 0.
- R8: At EOF with no record held, eof_bytes captures the input bytes since the previous EOF. Each ev_in_rd adds BEAT_BITS/8, including a read in the EOF cycle. The count wraps at 14 bits, and eof_valid is set.
- R9: An EOF arriving while eof_valid is 1, without a trace clear in the same cycle, sets eof_lost and leaves eof_bytes unchanged.
- R10: Writing bit 7 clears eof_valid, eof_lost and eof_bytes. An EOF in the same cycle is captured after the clear.
- R11: Writing bit 6 gives fifo_rst_pulse high for exactly the next cycle. Bits 6 and 7 always read as 0.
- R12: Clearing pause returns the state to run one clock after the write is visible, and the remaining trailing count is kept across the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| ctl_rdata | output | 8 | Control word readback, trigger bits zero |
| trail_bits | input | 16 | Trailing bits to process after EOF |
| ev_in_rd | input | 1 | Datapath read one input beat |
| ev_out_wr | input | 1 | Datapath wrote one output beat |
| ev_eof | input | 1 | End-of-frame seen on input |
| ev_wb_done | input | 1 | Pending write-back completed |
| run_en | output | 1 | Datapath may run |
| dummy_in | output | 1 | Datapath should use dummy input |
| wb_discard | output | 1 | Pending write-back is dropped |
| fifo_rst_pulse | output | 1 | One-cycle FIFO reset |
| tail_done | output | 1 | Trailing bits finished |
| st_onehot | output | 4 | One-hot state status |
| eof_valid | output | 1 | A captured EOF count is held |
| eof_lost | output | 1 | An EOF could not be recorded |
| eof_bytes | output | 14 | Captured byte count |

## Verification
A control write appears on ctl_rdata at the clock edge that takes it, and the state reacts at the following edge. wb_discard, tail_done, fifo_rst_pulse and the EOF record all change on the same edge as the event that causes them. The bench therefore drives on the falling edge and checks at the next falling edge. For state checks it inserts the extra clock after each control write. The tail checks count beats one edge at a time, so a done pulse that comes early or late is caught. The random EOF and clear traffic is compared against a bench model updated once per edge.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_PAUSE = 2'd3
    } run_state_e;

    typedef struct packed {
        logic trace_clr;
        logic fifo_rst;
        logic dummy_rd;
        logic tail_on_out;
        logic halt_drop;
        logic halt;
        logic pause;
        logic enable;
    } ctl_word_t;

    localparam ctl_word_t CTL_RESET = '{
        trace_clr: 1'b0, fifo_rst: 1'b0, dummy_rd: 1'b0, tail_on_out: 1'b0,
        halt_drop: 1'b0, halt: 1'b1, pause: 1'b0, enable: 1'b0
    };

    function automatic logic [3:0] state_onehot(run_state_e s);
        logic [3:0] v;
        v = 4'b0000;
        v[s] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/sr_ctlreg.sv
module sr_ctlreg
    import sr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  ctl_word_t wdata,
    output ctl_word_t cfg,
    output logic      fifo_pulse,
    output logic      clr_now
);
    ctl_word_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held       <= CTL_RESET;
            fifo_pulse <= 1'b0;
        end else begin
            fifo_pulse <= we & wdata.fifo_rst;
            if (we) begin
                held           <= wdata;
                held.fifo_rst  <= 1'b0;
                held.trace_clr <= 1'b0;
            end
        end
    end

    assign cfg     = held;
    assign clr_now = we & wdata.trace_clr;
endmodule

// File: rtl/sr_fsm.sv
module sr_fsm
    import sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       pause,
    input  logic       halt,
    input  logic       halt_drop,
    input  logic       wb_done,
    output run_state_e state,
    output logic       discard
);
    run_state_e nxt;
    logic       stop_req;

    assign stop_req = halt | ~enable;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:
                if (enable && !halt) nxt = pause ? ST_PAUSE : ST_RUN;
            ST_RUN, ST_PAUSE:
                if (stop_req)   nxt = halt_drop ? ST_IDLE : ST_WAIT;
                else if (pause) nxt = ST_PAUSE;
                else            nxt = ST_RUN;
            ST_WAIT:
                if (wb_done || halt_drop) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            discard <= 1'b0;
        end else begin
            state   <= nxt;
            discard <= (state != ST_IDLE) && (nxt == ST_IDLE) && halt_drop;
        end
    end
endmodule

// File: rtl/sr_tail.sv
module sr_tail #(
    parameter int TRAIL_W   = 16,
    parameter int BEAT_BITS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_idle,
    input  logic               in_run,
    input  logic               eof,
    input  logic [TRAIL_W-1:0] trail_bits,
    input  logic               count_evt,
    output logic               active,
    output logic               done
);
    localparam logic [TRAIL_W-1:0] BEAT = TRAIL_W'(BEAT_BITS);

    logic [TRAIL_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || in_idle) begin
            active <= 1'b0;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (eof) begin
                if (trail_bits == '0) begin
                    active <= 1'b0;
                    remain <= '0;
                    done   <= 1'b1;
                end else begin
                    active <= 1'b1;
                    remain <= trail_bits;
                end
            end else if (active && in_run && count_evt) begin
                if (remain <= BEAT) begin
                    remain <= '0;
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    remain <= remain - BEAT;
                end
            end
        end
    end
endmodule

// File: rtl/sr_eoftrk.sv
module sr_eoftrk #(
    parameter int BYTE_W    = 14,
    parameter int BEAT_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eof,
    input  logic              rd,
    input  logic              clr,
    output logic              valid,
    output logic              lost,
    output logic [BYTE_W-1:0] bytes
);
    localparam logic [BYTE_W-1:0] STEP = BYTE_W'(BEAT_BITS / 8);

    logic [BYTE_W-1:0] run_cnt, cap;
    logic              valid_n, lost_n;
    logic [BYTE_W-1:0] bytes_n;

    assign cap = run_cnt + (rd ? STEP : '0);

    always_comb begin
        valid_n = clr ? 1'b0 : valid;
        lost_n  = clr ? 1'b0 : lost;
        bytes_n = clr ? '0   : bytes;
        if (eof) begin
            if (!valid_n) begin
                bytes_n = cap;
                valid_n = 1'b1;
            end else begin
                lost_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            valid   <= 1'b0;
            lost    <= 1'b0;
            bytes   <= '0;
        end else begin
            run_cnt <= eof ? '0 : cap;
            valid   <= valid_n;
            lost    <= lost_n;
            bytes   <= bytes_n;
        end
    end
endmodule

// File: rtl/stream_runctl.sv
module stream_runctl
    import sr_pkg::*;
#(
    parameter int TRAIL_W   = 16,
    parameter int BYTE_W    = 14,
    parameter int BEAT_BITS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_we,
    input  logic [7:0]         ctl_wdata,
    output logic [7:0]         ctl_rdata,
    input  logic [TRAIL_W-1:0] trail_bits,
    input  logic               ev_in_rd,
    input  logic               ev_out_wr,
    input  logic               ev_eof,
    input  logic               ev_wb_done,
    output logic               run_en,
    output logic               dummy_in,
    output logic               wb_discard,
    output logic               fifo_rst_pulse,
    output logic               tail_done,
    output logic [3:0]         st_onehot,
    output logic               eof_valid,
    output logic               eof_lost,
    output logic [BYTE_W-1:0]  eof_bytes
);
    ctl_word_t  cfg;
    logic       clr_now;
    run_state_e state;
    logic       tail_active;
    logic       count_evt;

    sr_ctlreg u_ctl (
        .clk        (clk),
        .rst        (rst),
        .we         (ctl_we),
        .wdata      (ctl_word_t'(ctl_wdata)),
        .cfg        (cfg),
        .fifo_pulse (fifo_rst_pulse),
        .clr_now    (clr_now)
    );

    sr_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .enable    (cfg.enable),
        .pause     (cfg.pause),
        .halt      (cfg.halt),
        .halt_drop (cfg.halt_drop),
        .wb_done   (ev_wb_done),
        .state     (state),
        .discard   (wb_discard)
    );

    assign run_en    = (state == ST_RUN);
    assign dummy_in  = run_en & tail_active & cfg.dummy_rd;
    assign count_evt = cfg.tail_on_out ? ev_out_wr : (ev_in_rd | dummy_in);

    sr_tail #(.TRAIL_W(TRAIL_W), .BEAT_BITS(BEAT_BITS)) u_tail (
        .clk        (clk),
        .rst        (rst),
        .in_idle    (state == ST_IDLE),
        .in_run     (run_en),
        .eof        (ev_eof),
        .trail_bits (trail_bits),
        .count_evt  (count_evt),
        .active     (tail_active),
        .done       (tail_done)
    );

    sr_eoftrk #(.BYTE_W(BYTE_W), .BEAT_BITS(BEAT_BITS)) u_eof (
        .clk   (clk),
        .rst   (rst),
        .eof   (ev_eof),
        .rd    (ev_in_rd),
        .clr   (clr_now),
        .valid (eof_valid),
        .lost  (eof_lost),
        .bytes (eof_bytes)
    );

    assign ctl_rdata = cfg;
    assign st_onehot = state_onehot(state);
endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
    parameter int BYTE_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_we,
    input logic [7:0]        ctl_wdata,
    input logic [7:0]        ctl_rdata,
    input logic              ev_eof,
    input logic              ev_wb_done,
    input logic              fifo_rst_pulse,
    input logic [3:0]        st_onehot,
    input logic              eof_valid,
    input logic              eof_lost,
    input logic [BYTE_W-1:0] eof_bytes
);
    p_state_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(st_onehot) == 1);

    p_drop_to_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (st_onehot[1] && ctl_rdata[2] && ctl_rdata[3]) |=> st_onehot[0]);

    p_wait_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (st_onehot[2] && !ev_wb_done && !ctl_rdata[3]) |=> st_onehot[2]);

    p_lost_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (eof_valid && ev_eof && !(ctl_we && ctl_wdata[7])) |=> (eof_lost && $stable(eof_bytes)));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[7] && !ev_eof) |=> (!eof_valid && !eof_lost));

    p_fifo_cause_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_rst_pulse |-> $past(ctl_we && ctl_wdata[6]));

    p_trig_zero_r11: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[7:6] == 2'b00);

    p_unpause_r12: assert property (@(posedge clk) disable iff (rst)
        (st_onehot[3] && ctl_rdata[0] && !ctl_rdata[1] && !ctl_rdata[2]) |=> st_onehot[1]);
endmodule

bind stream_runctl sr_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ctl_we         (ctl_we),
    .ctl_wdata      (ctl_wdata),
    .ctl_rdata      (ctl_rdata),
    .ev_eof         (ev_eof),
    .ev_wb_done     (ev_wb_done),
    .fifo_rst_pulse (fifo_rst_pulse),
    .st_onehot      (st_onehot),
    .eof_valid      (eof_valid),
    .eof_lost       (eof_lost),
    .eof_bytes      (eof_bytes)
);

// File: tb/test_stream_runctl.sv
module test_stream_runctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic [7:0]  ctl_rdata;
    logic [15:0] trail_bits = 16'd0;
    logic        ev_in_rd = 1'b0, ev_out_wr = 1'b0, ev_eof = 1'b0, ev_wb_done = 1'b0;
    logic        run_en, dummy_in, wb_discard, fifo_rst_pulse, tail_done;
    logic [3:0]  st_onehot;
    logic        eof_valid, eof_lost;
    logic [13:0] eof_bytes;

    int nchk = 0;
    int nbad = 0;

    stream_runctl i_stream_runctl (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .trail_bits(trail_bits), .ev_in_rd(ev_in_rd), .ev_out_wr(ev_out_wr), .ev_eof(ev_eof),
        .ev_wb_done(ev_wb_done), .run_en(run_en), .dummy_in(dummy_in), .wb_discard(wb_discard),
        .fifo_rst_pulse(fifo_rst_pulse), .tail_done(tail_done), .st_onehot(st_onehot),
        .eof_valid(eof_valid), .eof_lost(eof_lost), .eof_bytes(eof_bytes)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        tick();
        ctl_we = 1'b0; ctl_wdata = 8'h00;
    endtask

    task automatic pulse_rd();  ev_in_rd = 1'b1;  tick(); ev_in_rd = 1'b0;  endtask
    task automatic pulse_wr();  ev_out_wr = 1'b1; tick(); ev_out_wr = 1'b0; endtask
    task automatic pulse_eof(); ev_eof = 1'b1;    tick(); ev_eof = 1'b0;    endtask

    // bench model of the EOF record
    logic        m_valid = 1'b0, m_lost = 1'b0;
    logic [13:0] m_bytes = '0, m_run = '0;

    function automatic int pack_rec(logic v, logic l, logic [13:0] b);
        return {v, l, b};
    endfunction

    task automatic model_step(input logic rd, input logic eof, input logic clr);
        logic [13:0] cap;
        cap = m_run + (rd ? 14'd1 : 14'd0);
        if (clr) begin m_valid = 1'b0; m_lost = 1'b0; m_bytes = '0; end
        if (eof) begin
            if (!m_valid) begin m_bytes = cap; m_valid = 1'b1; end
            else m_lost = 1'b1;
            m_run = '0;
        end else m_run = cap;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog R1 act=timeout exp=finished");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 rdata", ctl_rdata, 8'h04);
        check("R1 state", st_onehot, 4'b0001);
        check("R1 run_en", run_en, 0);
        check("R1 eof", pack_rec(eof_valid, eof_lost, eof_bytes), 0);

        // R4 enable: readback now, state one edge later
        wr_ctl(8'h01);
        check("R4 rdata", ctl_rdata, 8'h01);
        check("R4 latency", st_onehot, 4'b0001);
        tick();
        check("R4 run", st_onehot, 4'b0010);
        check("R2 run_en", run_en, 1);

        // R4/R12 pause and resume
        wr_ctl(8'h03); tick();
        check("R4 pause", st_onehot, 4'b1000);
        check("R4 pause run_en", run_en, 0);
        wr_ctl(8'h01);
        check("R12 still paused", st_onehot, 4'b1000);
        tick();
        check("R12 resume", st_onehot, 4'b0010);

        // R4 halt beats pause, R3 wait for write-back
        wr_ctl(8'h07); tick();
        check("R4 halt priority", st_onehot, 4'b0100);
        tick(); tick();
        check("R3 wait holds", st_onehot, 4'b0100);
        ev_wb_done = 1'b1; tick(); ev_wb_done = 1'b0;
        check("R3 wait to idle", st_onehot, 4'b0001);
        check("R3 no discard", wb_discard, 0);

        // R3 drop path
        wr_ctl(8'h01); tick();
        wr_ctl(8'h0D); tick();
        check("R3 drop idle", st_onehot, 4'b0001);
        check("R3 discard", wb_discard, 1);
        tick();
        check("R3 discard once", wb_discard, 0);

        // R5/R12 tail on input side, 20 bits = 3 beats
        wr_ctl(8'h01); tick();
        trail_bits = 16'd20;
        pulse_eof();
        check("R7 no dummy", dummy_in, 0);
        pulse_wr();
        check("R5 out ignored", tail_done, 0);
        pulse_rd();
        check("R5 beat1", tail_done, 0);
        wr_ctl(8'h03); tick();
        check("R12 paused", st_onehot, 4'b1000);
        pulse_rd();
        check("R5 pause ignores", tail_done, 0);
        wr_ctl(8'h01); tick();
        pulse_rd();
        check("R12 count kept", tail_done, 0);
        pulse_rd();
        check("R6 done", tail_done, 1);
        tick();
        check("R6 one cycle", tail_done, 0);

        // R5 output side, 16 bits = 2 beats
        wr_ctl(8'h11);
        trail_bits = 16'd16;
        pulse_eof();
        pulse_rd();
        check("R5 in ignored", tail_done, 0);
        pulse_wr();
        check("R5 out beat1", tail_done, 0);
        pulse_wr();
        check("R5 out done", tail_done, 1);

        // R6 zero trailing bits
        trail_bits = 16'd0;
        pulse_eof();
        check("R6 zero tail", tail_done, 1);

        // R7 dummy input, 24 bits = 3 run cycles
        wr_ctl(8'h21);
        trail_bits = 16'd24;
        pulse_eof();
        check("R7 dummy on", dummy_in, 1);
        check("R7 cyc0", tail_done, 0);
        tick();
        check("R7 cyc1", tail_done, 0);
        tick();
        check("R7 cyc2", tail_done, 0);
        tick();
        check("R7 done", tail_done, 1);
        check("R7 dummy off", dummy_in, 0);

        // R8-R10 EOF record
        wr_ctl(8'h81);
        check("R10 clear", pack_rec(eof_valid, eof_lost, eof_bytes), 0);
        for (int i = 0; i < 5; i++) pulse_rd();
        ev_in_rd = 1'b1; pulse_eof(); ev_in_rd = 1'b0;
        check("R8 capture", pack_rec(eof_valid, eof_lost, eof_bytes), pack_rec(1, 0, 14'd6));
        pulse_eof();
        check("R9 lost", pack_rec(eof_valid, eof_lost, eof_bytes), pack_rec(1, 1, 14'd6));
        for (int i = 0; i < 3; i++) pulse_rd();
        ev_eof = 1'b1; wr_ctl(8'h81); ev_eof = 1'b0;
        check("R10 clear with eof", pack_rec(eof_valid, eof_lost, eof_bytes), pack_rec(1, 0, 14'd3));

        // R11 fifo reset trigger
        wr_ctl(8'h41);
        check("R11 pulse", fifo_rst_pulse, 1);
        check("R11 reads zero", ctl_rdata, 8'h01);
        tick();
        check("R11 single", fifo_rst_pulse, 0);

        // sync model: clear record, running count is 0 since last EOF
        wr_ctl(8'h81);

        // random traffic on R8-R10
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            logic rd, eof, clr;
            rd  = $urandom % 2;
            eof = ($urandom % 8) == 0;
            clr = ($urandom % 16) == 0;
            ev_in_rd = rd; ev_eof = eof;
            ctl_we = clr; ctl_wdata = clr ? 8'h81 : 8'h00;
            tick();
            model_step(rd, eof, clr);
            check("R8 R9 R10 random", pack_rec(eof_valid, eof_lost, eof_bytes),
                  pack_rec(m_valid, m_lost, m_bytes));
        end
        ev_in_rd = 1'b0; ev_eof = 1'b0; ctl_we = 1'b0; ctl_wdata = 8'h00;

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule